// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block is the command front end on the device side of a four-bank synchronous DRAM. On every rising clock edge it samples the four active-low command strobes (chip select, row strobe, column strobe, write enable), the two bank-select bits, the twelve address bits and the clock-enable input. From these it decodes the following commands:

- bank activate
- single-bank precharge
- all-bank precharge
- read
- write
- mode register load

It keeps an idle or active flag and the open row for each bank. It also reports the accepted command, the bank it targets, the captured row or column address and the auto-precharge request.

Address bit 10 has two uses. On a precharge it widens the command to every bank. On a read or write it asks for the bank to close by itself after the access. A command that does not fit the current bank state is refused and reported as no operation, and it sets a sticky protocol-error flag. When clock enable is sampled low, internal operation freezes from the next edge. If every bank is idle at that point, the block also enters power-down. It leaves power-down as soon as clock enable rises, without waiting for a clock edge.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset, cmd_o is 0 (no operation), every bank is idle, proto_err_o and power_down_o are 0, and mode_o and all open-row slots are 0.
- R2: When cs_n is high at an accepting edge, cmd_o becomes 0 and no command takes effect, whatever the other strobes hold.
- R3: Strobes cs_n=0, ras_n=0, cas_n=1, we_n=1 on an idle bank give cmd_o=1. That bank becomes active, and the address is stored in row_o and in that bank's open-row slot.
- R4: Strobes cs_n=0, ras_n=0, cas_n=1, we_n=0 give precharge. With addr[10]=0, cmd_o=2 and the selected bank goes idle. With addr[10]=1, cmd_o=3 and all banks go idle.
- R5: Strobes cs_n=0, ras_n=1, cas_n=0 on an active bank give cmd_o=4 (read) when we_n=1 and cmd_o=5 (write) when we_n=0. cmd_bank_o shows the target bank.
- R6: On an accepted read or write, col_o takes addr[8:0] and auto_pre_o takes addr[10].
- R7: All four strobes low gives cmd_o=6 and loads mode_o from the address, but only when all banks are idle. Otherwise the command is refused under R10 and mode_o keeps its value.
- R8: Bank-select value n addresses bank n. That bank is bit n of bank_active_o and bits n*12 to n*12+11 of open_rows_o.
- R9: If cke is low at an edge, the command at that edge still executes. Every later edge, up to and including the one at which cke is sampled high again, is ignored, and all outputs hold their values.
- R10: Activating an active bank, reading or writing an idle bank, or loading the mode while any bank is active reports cmd_o=0 and leaves bank state, rows and mode unchanged. It sets proto_err_o, which stays high until reset.
- R11: A read or write with addr[10]=1 keeps its bank active after its own edge and closes it at the next accepting edge. A command at that edge sees the bank as idle.
- R12: Refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1), burst stop (cs_n=0, ras_n=1, cas_n=1, we_n=0) and the explicit no-operation pattern give cmd_o=0 and change no bank state.
- R13: When cke is low at an accepting edge and every bank is idle after that edge, power_down_o goes high. It drops as soon as cke goes high, without waiting for an edge. It never rises while a bank is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row address, column address or mode op-code |
| cmd_o | output | 3 | Accepted command code |
| cmd_bank_o | output | 2 | Bank of the last sampled command |
| row_o | output | 12 | Row of the last accepted activate |
| col_o | output | 9 | Column of the last accepted read or write |
| auto_pre_o | output | 1 | Auto-precharge request of the last read or write |
| mode_o | output | 12 | Last loaded mode op-code |
| bank_active_o | output | 4 | Active flag per bank |
| open_rows_o | output | 48 | Open row per bank, 12 bits each |
| proto_err_o | output | 1 | Sticky protocol-error flag |
| power_down_o | output | 1 | Power-down indication |

## Verification
The bench checks that the address-bit-10 overload is decoded correctly in both commands. A design that confused the two cases would close only one bank on an all-bank precharge, or would close a bank immediately rather than one edge after an auto-precharge access. It also checks that an activate issued in the edge right after an auto-precharge access is accepted; a design that ignored the pending close would refuse it. Around clock enable, it confirms that the command sampled together with a low clock enable still executes and that the edge where clock enable returns high is still ignored. It also confirms that power-down is entered only with all banks idle and drops without waiting for an edge. A design that got these wrong would lose or add a command, or would stay in power-down for a cycle too long. Refused commands are checked for leaving the open rows and the mode untouched while the error flag stays set.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_PRE  = 3'd2,
    CMD_PREA = 3'd3,
    CMD_RD   = 3'd4,
    CMD_WR   = 3'd5,
    CMD_MRS  = 3'd6
  } cmd_e;
endpackage

// File: rtl/sdcf_decode.sv
module sdcf_decode
  import sdcf_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic all_bit,
  output cmd_e raw_o
);
  always_comb begin
    raw_o = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  raw_o = CMD_ACT;
        3'b010:  raw_o = all_bit ? CMD_PREA : CMD_PRE;
        3'b101:  raw_o = CMD_RD;
        3'b100:  raw_o = CMD_WR;
        3'b000:  raw_o = CMD_MRS;
        default: raw_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcf_bank.sv
module sdcf_bank #(
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             open_i,
  input  logic             close_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             active_o,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  logic             active_q, active_d;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    active_d = active_q;
    pend_d   = pend_q;
    row_d    = row_q;
    if (en) begin
      if (pend_q) begin
        active_d = 1'b0;
        pend_d   = 1'b0;
      end
      if (close_i) active_d = 1'b0;
      if (open_i) begin
        active_d = 1'b1;
        row_d    = row_i;
      end
      if (ap_i) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      row_q    <= '0;
    end else begin
      active_q <= active_d;
      pend_q   <= pend_d;
      row_q    <= row_d;
    end
  end

  assign active_o = active_q;
  assign pend_o   = pend_q;
  assign row_o    = row_q;
endmodule

// File: rtl/sdcf_cke_ctrl.sv
module sdcf_cke_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic idle_after,
  output logic en_o,
  output logic pd_o
);
  logic cke_q;
  logic pd_q, pd_d;

  always_comb begin
    pd_d = pd_q;
    if (pd_q) begin
      if (cke) pd_d = 1'b0;
    end else if (cke_q && !cke && idle_after) begin
      pd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q <= 1'b1;
      pd_q  <= 1'b0;
    end else begin
      cke_q <= cke;
      pd_q  <= pd_d;
    end
  end

  assign en_o = cke_q;
  assign pd_o = pd_q & ~cke;
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdcf_pkg::*;
#(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned AP_BIT = 10,
  localparam int unsigned BA_W  = $clog2(BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic [ROW_W-1:0]       addr,
  output logic [2:0]             cmd_o,
  output logic [BA_W-1:0]        cmd_bank_o,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o,
  output logic                   auto_pre_o,
  output logic [ROW_W-1:0]       mode_o,
  output logic [BANKS-1:0]       bank_active_o,
  output logic [BANKS*ROW_W-1:0] open_rows_o,
  output logic                   proto_err_o,
  output logic                   power_down_o
);
  cmd_e             raw;
  cmd_e             acc;
  logic             en;
  logic             legal;
  logic             idle_after;
  logic [BANKS-1:0] active, pend, eff_active;
  logic [BANKS-1:0] open_v, close_v, ap_v;

  sdcf_decode i_decode (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .all_bit(addr[AP_BIT]), .raw_o(raw)
  );

  sdcf_cke_ctrl i_cke (
    .clk(clk), .rst_n(rst_n), .cke(cke), .idle_after(idle_after),
    .en_o(en), .pd_o(power_down_o)
  );

  assign eff_active = active & ~pend;

  always_comb begin
    unique case (raw)
      CMD_ACT:        legal = ~eff_active[ba];
      CMD_RD, CMD_WR: legal = eff_active[ba];
      CMD_MRS:        legal = (eff_active == '0);
      default:        legal = 1'b1;
    endcase
    acc = (en && legal) ? raw : CMD_NOP;
  end

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign open_v[b]  = (acc == CMD_ACT) && (ba == BA_W'(b));
      assign close_v[b] = ((acc == CMD_PRE) && (ba == BA_W'(b))) || (acc == CMD_PREA);
      assign ap_v[b]    = ((acc == CMD_RD) || (acc == CMD_WR)) &&
                          (ba == BA_W'(b)) && addr[AP_BIT];
      sdcf_bank #(.ROW_W(ROW_W)) i_bank (
        .clk(clk), .rst_n(rst_n), .en(en),
        .open_i(open_v[b]), .close_i(close_v[b]), .ap_i(ap_v[b]),
        .row_i(addr),
        .active_o(active[b]), .pend_o(pend[b]),
        .row_o(open_rows_o[b*ROW_W +: ROW_W])
      );
    end
  endgenerate

  assign idle_after    = ((eff_active & ~close_v) == '0) && (acc != CMD_ACT);
  assign bank_active_o = active;

  logic [2:0]       cmd_q, cmd_d;
  logic [BA_W-1:0]  bank_q, bank_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             ap_q, ap_d;
  logic [ROW_W-1:0] mode_q, mode_d;
  logic             err_q, err_d;

  always_comb begin
    cmd_d  = cmd_q;
    bank_d = bank_q;
    row_d  = row_q;
    col_d  = col_q;
    ap_d   = ap_q;
    mode_d = mode_q;
    err_d  = err_q;
    if (en) begin
      cmd_d  = acc;
      bank_d = ba;
      if (!legal) err_d = 1'b1;
      if (acc == CMD_ACT) row_d = addr;
      if ((acc == CMD_RD) || (acc == CMD_WR)) begin
        col_d = addr[COL_W-1:0];
        ap_d  = addr[AP_BIT];
      end
      if (acc == CMD_MRS) mode_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      bank_q <= bank_d;
      row_q  <= row_d;
      col_q  <= col_d;
      ap_q   <= ap_d;
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign cmd_o       = cmd_q;
  assign cmd_bank_o  = bank_q;
  assign row_o       = row_q;
  assign col_o       = col_q;
  assign auto_pre_o  = ap_q;
  assign mode_o      = mode_q;
  assign proto_err_o = err_q;
endmodule

// File: rtl/sdcf_checker.sv
module sdcf_checker #(
  parameter int unsigned BANKS = 4,
  localparam int unsigned BA_W = $clog2(BANKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             cs_n,
  input logic [2:0]       cmd_o,
  input logic [BA_W-1:0]  cmd_bank_o,
  input logic [BANKS-1:0] bank_active_o,
  input logic             proto_err_o,
  input logic             power_down_o
);
  a_r2_cs_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cs_n) |=> (cmd_o == 3'd0));

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cmd_o) && $stable(bank_active_o)));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);

  a_r7_mrs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd6) |-> (bank_active_o == '0));

  a_r13_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    power_down_o |-> (bank_active_o == '0));

  a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd1) |-> bank_active_o[cmd_bank_o]);

  a_r4_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd3) |-> (bank_active_o == '0));
endmodule

bind sdram_cmd_front sdcf_checker #(.BANKS(BANKS)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cs_n(cs_n),
  .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .bank_active_o(bank_active_o),
  .proto_err_o(proto_err_o), .power_down_o(power_down_o)
);

// File: tb/test_sdram_cmd_front.sv
`timescale 1ns/1ps
module test_sdram_cmd_front;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [2:0]  cmd_o;
  logic [1:0]  cmd_bank_o;
  logic [11:0] row_o;
  logic [8:0]  col_o;
  logic        auto_pre_o;
  logic [11:0] mode_o;
  logic [3:0]  bank_active_o;
  logic [47:0] open_rows_o;
  logic        proto_err_o, power_down_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_front i_sdram_cmd_front (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .row_o(row_o), .col_o(col_o),
    .auto_pre_o(auto_pre_o), .mode_o(mode_o), .bank_active_o(bank_active_o),
    .open_rows_o(open_rows_o), .proto_err_o(proto_err_o),
    .power_down_o(power_down_o)
  );

  typedef struct {
    logic [2:0]  cmd;
    logic [3:0]  act;
    logic        err;
    logic        pd;
    int          kind;
    logic [47:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];

  task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic k, c, r, ca, w, input logic [1:0] b,
                      input logic [11:0] a, input logic [2:0] ec,
                      input logic [3:0] ea, input logic ee, ep,
                      input int kind, input logic [47:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    e.cmd = ec; e.act = ea; e.err = ee; e.pd = ep; e.kind = kind; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " cmd"}, 48'(cmd_o), 48'(e.cmd));
        check({e.tag, " active"}, 48'(bank_active_o), 48'(e.act));
        check({e.tag, " err"}, 48'(proto_err_o), 48'(e.err));
        check({e.tag, " pd"}, 48'(power_down_o), 48'(e.pd));
        case (e.kind)
          1: check({e.tag, " row"}, 48'(row_o), e.val);
          2: check({e.tag, " ap/col"}, 48'({auto_pre_o, col_o}), e.val);
          3: check({e.tag, " mode"}, 48'(mode_o), e.val);
          4: check({e.tag, " open rows"}, open_rows_o, e.val);
          5: check({e.tag, " bank"}, 48'(cmd_bank_o), e.val);
          default: ;
        endcase
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1;
    we_n = 1'b1; ba = 2'd0; addr = 12'h000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 cmd", 48'(cmd_o), 48'd0);
    check("R1 active", 48'(bank_active_o), 48'd0);
    check("R1 err", 48'(proto_err_o), 48'd0);
    check("R1 pd", 48'(power_down_o), 48'd0);
    check("R1 mode", 48'(mode_o), 48'd0);
    check("R1 rows", open_rows_o, 48'd0);

    // args: cke cs ras cas we ba addr | cmd act err pd kind val tag
    step(1,1,0,0,0, 2'd0, 12'hFFF, 3'd0, 4'b0000, 0, 0, 3, 48'h0,   "R2 cs high masks");
    step(1,0,0,0,0, 2'd0, 12'h033, 3'd6, 4'b0000, 0, 0, 3, 48'h33,  "R7 mode load");
    step(1,0,0,1,1, 2'd1, 12'hABC, 3'd1, 4'b0010, 0, 0, 1, 48'hABC, "R3 activate b1");
    step(1,0,0,1,1, 2'd3, 12'h123, 3'd1, 4'b1010, 0, 0, 4,
         {12'h123, 12'h000, 12'hABC, 12'h000}, "R8 activate b3");
    step(1,0,1,0,1, 2'd1, 12'h9FF, 3'd4, 4'b1010, 0, 0, 2, 48'h1FF, "R5 R6 read b1");
    step(1,0,1,0,0, 2'd3, 12'h405, 3'd5, 4'b1010, 0, 0, 2, 48'h205, "R6 R11 write ap b3");
    step(1,1,1,1,1, 2'd0, 12'h000, 3'd0, 4'b0010, 0, 0, 0, 48'h0,   "R11 ap closes b3");
    step(1,0,1,0,1, 2'd0, 12'h000, 3'd0, 4'b0010, 1, 0, 0, 48'h0,   "R10 read idle bank");
    step(1,0,0,1,1, 2'd1, 12'h555, 3'd0, 4'b0010, 1, 0, 4,
         {12'h123, 12'h000, 12'hABC, 12'h000}, "R10 reactivate b1");
    step(1,0,0,0,0, 2'd0, 12'h777, 3'd0, 4'b0010, 1, 0, 3, 48'h33,  "R7 mode refused");
    step(1,0,0,1,1, 2'd0, 12'h001, 3'd1, 4'b0011, 1, 0, 0, 48'h0,   "R3 activate b0");
    step(1,0,0,1,1, 2'd2, 12'h002, 3'd1, 4'b0111, 1, 0, 5, 48'h2,   "R8 activate b2");
    step(1,0,0,1,0, 2'd1, 12'h000, 3'd2, 4'b0101, 1, 0, 0, 48'h0,   "R4 precharge b1");
    step(1,0,0,1,0, 2'd0, 12'h400, 3'd3, 4'b0000, 1, 0, 0, 48'h0,   "R4 precharge all");
    step(1,0,0,0,1, 2'd0, 12'h000, 3'd0, 4'b0000, 1, 0, 0, 48'h0,   "R12 refresh ignored");
    step(1,0,1,1,0, 2'd0, 12'h000, 3'd0, 4'b0000, 1, 0, 0, 48'h0,   "R12 burst stop ignored");
    step(0,0,0,1,1, 2'd2, 12'h055, 3'd1, 4'b0100, 1, 0, 0, 48'h0,   "R9 R13 cmd with cke low");
    step(0,0,1,0,1, 2'd2, 12'h000, 3'd1, 4'b0100, 1, 0, 0, 48'h0,   "R9 suspended");
    step(1,0,0,1,0, 2'd2, 12'h000, 3'd1, 4'b0100, 1, 0, 0, 48'h0,   "R9 cke rise edge ignored");
    step(1,0,0,1,0, 2'd2, 12'h000, 3'd2, 4'b0000, 1, 0, 0, 48'h0,   "R9 resumed");
    step(0,1,1,1,1, 2'd0, 12'h000, 3'd0, 4'b0000, 1, 1, 0, 48'h0,   "R13 power-down entry");
    step(0,0,0,1,1, 2'd0, 12'h000, 3'd0, 4'b0000, 1, 1, 0, 48'h0,   "R13 held in power-down");
    step(1,1,1,1,1, 2'd0, 12'h000, 3'd0, 4'b0000, 1, 0, 0, 48'h0,   "R13 exit");
    #1;
    check("R13 async exit", 48'(power_down_o), 48'd0);
    step(1,0,0,1,1, 2'd0, 12'h007, 3'd1, 4'b0001, 1, 0, 1, 48'h7,   "R9 after wake");
    step(1,0,1,0,1, 2'd0, 12'h400, 3'd4, 4'b0001, 1, 0, 2, 48'h200, "R11 read ap b0");
    step(1,0,0,1,1, 2'd0, 12'h0FF, 3'd1, 4'b0001, 1, 0, 4,
         {12'h123, 12'h055, 12'hABC, 12'h0FF}, "R11 activate after ap");
    step(1,1,1,1,1, 2'd0, 12'h000, 3'd0, 4'b0001, 1, 0, 0, 48'h0,   "R2 idle");

    repeat (4) @(posedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule